// File: doc/BRIEF.md
# Debug-Aware Low-Power Mode Controller

This block decides which power mode the device is in when software asks to go to sleep while a debugger may be attached. A debugger raises two power-up requests, one for system power and one for debug power. The controller answers each with its own acknowledge while the device is running or idling, in either the full-power or the low-power family, provided the device is not secured.

Software asks for a new mode by pulsing a request with a mode code. When both debugger requests are held and software asks for one of the two stop modes, the controller substitutes an emulated stop. In that state the regulator stays in full regulation, the clock generator keeps running and the core clock stays on, so the debugger can still reach the core. Every other system clock is gated off and bus access to on-chip peripherals is blocked. The state-retention mode and the deep power-down mode are modelled only as states in which debug is unavailable. An interrupt wake brings the device out of all sleep states.

The outputs drive the regulator mode, the clock generator enable, a vector of system clock gates, the core clock gate and a peripheral-block strobe. The current mode code is also reported.

Top module: `dbg_lpm_ctrl`

## Requirements
- R1: After reset the mode is 0 (run), both acknowledges are low, the regulator is in full regulation, the clock source, core clock and all system clocks are enabled and peripheral blocking is off.
- R2: When the device is not secured and the mode is 0, 1, 2 or 3 (run, idle, low-power run, low-power idle), each asserted power-up request raises its own acknowledge on the next clock edge, independently of the other request.
- R3: While the secure input is high, both acknowledges are low from the next edge on, and a stop request with both power-up requests held enters real stop (mode 4), not emulated stop.
- R4: An acknowledge falls on the first clock edge after its request drops. Both acknowledges fall on the same edge on which the mode becomes 7 (retention) or 8 (deep power-down), and they stay low in those modes.
- R5: With both requests held and the device not secured, a request for mode 4 (stop) or 5 (low-power stop) made from an active mode enters mode 6 (emulated stop) on the next edge.
- R6: In mode 6 the regulator is in full regulation, the clock source and core clock are enabled, all system clocks are gated off and peripheral blocking is high. Peripheral blocking is low in every other mode.
- R7: Mode 6 is left on the edge after a wake or after either power-up request drops, and it returns to the active mode from which it was entered.
- R8: When the stop request is not redirected, mode 4 or 5 gates the core clock and all system clocks off, drops the clock source and leaves full regulation.
- R9: A wake in mode 7 returns to mode 0 on the next edge. If both requests are still held, both acknowledges rise on that same edge.
- R10: Mode codes are run=0, idle=1, low-power run=2, low-power idle=3, stop=4, low-power stop=5, emulated stop=6, retention=7, deep power-down=8. A request for code 6 or for any code above 8 is ignored. A request made while not in modes 0 to 3 is also ignored.
- R11: A wake moves mode 1 and mode 4 to mode 0, and mode 3 and mode 5 to mode 2, on the next edge.
- R12: Mode 2 leaves full regulation but keeps the clock source, core clock and system clocks on. Mode 1 gates the core clock only, with SYS_CLK_IN_IDLE=1 (the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| secure_i | input | 1 | Device secured; debugger requests are ignored |
| sys_pwr_req_i | input | 1 | Debugger system power-up request |
| dbg_pwr_req_i | input | 1 | Debugger debug power-up request |
| mode_req_valid_i | input | 1 | One-cycle strobe for a software mode request |
| mode_req_i | input | 4 | Requested mode code |
| wake_i | input | 1 | Interrupt wake |
| sys_pwr_ack_o | output | 1 | System power-up acknowledge |
| dbg_pwr_ack_o | output | 1 | Debug power-up acknowledge |
| mode_o | output | 4 | Current mode code |
| reg_run_o | output | 1 | Regulator in full (run) regulation |
| clk_src_en_o | output | 1 | Clock generator output enable |
| sys_clk_en_o | output | NUM_SYS_CLK | System clock gate enables |
| core_clk_en_o | output | 1 | Core clock gate enable |
| periph_block_o | output | 1 | Block bus access to on-chip peripherals |

## Verification
A wrong mode register shows up at once on mode_o. The clock, regulator and blocking outputs are decoded from that register with no delay, so they expose the same fault in the same cycle. A wrong saved return mode stays hidden until emulated stop is left, and then it appears as a wrong mode code one edge after the wake or the request drop. An acknowledge register that misses the secure gate or the mode gate is visible one edge after the stimulus. The directed sequences therefore check every output right after each edge that should change it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      MODE_RUN      = 4'd0,
      MODE_IDLE     = 4'd1,
      MODE_LP_RUN   = 4'd2,
      MODE_LP_IDLE  = 4'd3,
      MODE_STOP     = 4'd4,
      MODE_LP_STOP  = 4'd5,
      MODE_EMU_STOP = 4'd6,
      MODE_RETAIN   = 4'd7,
      MODE_DEEP_OFF = 4'd8
   } lpm_mode_e;

   // run / idle family that accepts software requests
   function automatic logic is_active(input lpm_mode_e m);
      return (m == MODE_RUN) || (m == MODE_IDLE) ||
             (m == MODE_LP_RUN) || (m == MODE_LP_IDLE);
   endfunction

   // modes in which a debugger acknowledge may be held
   function automatic logic ack_allowed(input lpm_mode_e m);
      return is_active(m) || (m == MODE_EMU_STOP);
   endfunction

   function automatic logic is_stop_code(input logic [MODE_W-1:0] c);
      return (c == MODE_STOP) || (c == MODE_LP_STOP);
   endfunction

   // emulated stop is never requested directly; codes above 8 are unused
   function automatic logic legal_code(input logic [MODE_W-1:0] c);
      return (c <= MODE_DEEP_OFF) && (c != MODE_EMU_STOP);
   endfunction

endpackage

// File: rtl/lpm_ack_cell.sv
module lpm_ack_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic secure_i,
   input  logic allow_i,
   output logic ack_o
);

   logic ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_i & ~secure_i & allow_i;
   end

   assign ack_o = ack_q;

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm import lpm_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [MODE_W-1:0] req_code_i,
   input  logic              wake_i,
   input  logic              both_dbg_i,
   output lpm_mode_e         mode_q_o,
   output lpm_mode_e         mode_d_o
);

   lpm_mode_e mode_q, mode_d;
   lpm_mode_e ret_q, ret_d;

   always_comb begin
      mode_d = mode_q;
      ret_d  = ret_q;
      case (mode_q)
         MODE_RUN, MODE_IDLE, MODE_LP_RUN, MODE_LP_IDLE: begin
            if (wake_i && mode_q == MODE_IDLE) begin
               mode_d = MODE_RUN;
            end else if (wake_i && mode_q == MODE_LP_IDLE) begin
               mode_d = MODE_LP_RUN;
            end else if (req_valid_i && legal_code(req_code_i)) begin
               if (is_stop_code(req_code_i) && both_dbg_i) begin
                  mode_d = MODE_EMU_STOP;
                  ret_d  = mode_q;
               end else begin
                  mode_d = lpm_mode_e'(req_code_i);
               end
            end
         end
         MODE_STOP, MODE_RETAIN, MODE_DEEP_OFF: begin
            if (wake_i) mode_d = MODE_RUN;
         end
         MODE_LP_STOP: begin
            if (wake_i) mode_d = MODE_LP_RUN;
         end
         MODE_EMU_STOP: begin
            if (wake_i || !both_dbg_i) mode_d = ret_q;
         end
         default: mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
         ret_q  <= MODE_RUN;
      end else begin
         mode_q <= mode_d;
         ret_q  <= ret_d;
      end
   end

   assign mode_q_o = mode_q;
   assign mode_d_o = mode_d;

endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode import lpm_pkg::*; #(
   parameter int NUM_SYS_CLK     = 4,
   parameter bit SYS_CLK_IN_IDLE = 1'b1
) (
   input  lpm_mode_e              mode_i,
   output logic                   reg_run_o,
   output logic                   clk_src_en_o,
   output logic [NUM_SYS_CLK-1:0] sys_clk_en_o,
   output logic                   core_clk_en_o,
   output logic                   periph_block_o
);

   logic run_like, idle_like, sys_on;

   assign run_like  = (mode_i == MODE_RUN) || (mode_i == MODE_LP_RUN);
   assign idle_like = (mode_i == MODE_IDLE) || (mode_i == MODE_LP_IDLE);

   assign reg_run_o      = (mode_i == MODE_RUN) || (mode_i == MODE_IDLE) ||
                           (mode_i == MODE_EMU_STOP);
   assign clk_src_en_o   = run_like || idle_like || (mode_i == MODE_EMU_STOP);
   assign core_clk_en_o  = run_like || (mode_i == MODE_EMU_STOP);
   assign periph_block_o = (mode_i == MODE_EMU_STOP);

   generate
      if (SYS_CLK_IN_IDLE) begin : g_idle_keep
         assign sys_on = run_like || idle_like;
      end else begin : g_idle_gate
         assign sys_on = run_like;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SYS_CLK; i++) begin : g_gate
         assign sys_clk_en_o[i] = sys_on;
      end
   endgenerate

endmodule

// File: rtl/dbg_lpm_ctrl.sv
module dbg_lpm_ctrl import lpm_pkg::*; #(
   parameter int NUM_SYS_CLK     = 4,
   parameter bit SYS_CLK_IN_IDLE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   secure_i,
   input  logic                   sys_pwr_req_i,
   input  logic                   dbg_pwr_req_i,
   input  logic                   mode_req_valid_i,
   input  logic [MODE_W-1:0]      mode_req_i,
   input  logic                   wake_i,
   output logic                   sys_pwr_ack_o,
   output logic                   dbg_pwr_ack_o,
   output logic [MODE_W-1:0]      mode_o,
   output logic                   reg_run_o,
   output logic                   clk_src_en_o,
   output logic [NUM_SYS_CLK-1:0] sys_clk_en_o,
   output logic                   core_clk_en_o,
   output logic                   periph_block_o
);

   localparam int NUM_CH = 2;

   generate
      if (NUM_SYS_CLK < 1 || NUM_SYS_CLK > 64) begin : g_bad_clk_count
         $error("NUM_SYS_CLK must lie in 1..64");
      end
   endgenerate

   lpm_mode_e         mode_q, mode_d;
   logic              both_dbg, allow_next;
   logic [NUM_CH-1:0] req_vec, ack_vec;

   assign both_dbg   = sys_pwr_req_i & dbg_pwr_req_i & ~secure_i;
   assign allow_next = ack_allowed(mode_d);
   assign req_vec    = {dbg_pwr_req_i, sys_pwr_req_i};

   lpm_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (mode_req_valid_i),
      .req_code_i  (mode_req_i),
      .wake_i      (wake_i),
      .both_dbg_i  (both_dbg),
      .mode_q_o    (mode_q),
      .mode_d_o    (mode_d)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
         lpm_ack_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_vec[g]),
            .secure_i (secure_i),
            .allow_i  (allow_next),
            .ack_o    (ack_vec[g])
         );
      end
   endgenerate

   lpm_out_decode #(
      .NUM_SYS_CLK     (NUM_SYS_CLK),
      .SYS_CLK_IN_IDLE (SYS_CLK_IN_IDLE)
   ) u_dec (
      .mode_i         (mode_q),
      .reg_run_o      (reg_run_o),
      .clk_src_en_o   (clk_src_en_o),
      .sys_clk_en_o   (sys_clk_en_o),
      .core_clk_en_o  (core_clk_en_o),
      .periph_block_o (periph_block_o)
   );

   assign sys_pwr_ack_o = ack_vec[0];
   assign dbg_pwr_ack_o = ack_vec[1];
   assign mode_o        = mode_q;

endmodule

// File: rtl/dbg_lpm_ctrl_chk.sv
module dbg_lpm_ctrl_chk #(
   parameter int NUM_SYS_CLK = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   secure_i,
   input logic                   sys_pwr_req_i,
   input logic                   dbg_pwr_req_i,
   input logic                   mode_req_valid_i,
   input logic [3:0]             mode_req_i,
   input logic                   wake_i,
   input logic                   sys_pwr_ack_o,
   input logic                   dbg_pwr_ack_o,
   input logic [3:0]             mode_o,
   input logic                   reg_run_o,
   input logic                   clk_src_en_o,
   input logic [NUM_SYS_CLK-1:0] sys_clk_en_o,
   input logic                   core_clk_en_o,
   input logic                   periph_block_o
);

   p_ack_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
      secure_i |=> (!sys_pwr_ack_o && !dbg_pwr_ack_o));

   p_sys_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_pwr_req_i |=> !sys_pwr_ack_o);

   p_dbg_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_pwr_req_i |=> !dbg_pwr_ack_o);

   p_no_ack_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd7 || mode_o == 4'd8) |-> !(sys_pwr_ack_o || dbg_pwr_ack_o));

   p_emu_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == 4'd0 || mode_o == 4'd2) && mode_req_valid_i &&
       (mode_req_i == 4'd4 || mode_req_i == 4'd5) &&
       sys_pwr_req_i && dbg_pwr_req_i && !secure_i) |=> (mode_o == 4'd6));

   p_emu_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd6) |-> (reg_run_o && clk_src_en_o && core_clk_en_o &&
                            sys_clk_en_o == '0));

   p_block_only_emu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      periph_block_o |-> (mode_o == 4'd6));

   p_emu_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd6 && (!sys_pwr_req_i || !dbg_pwr_req_i || wake_i))
      |=> (mode_o != 4'd6));

   p_stop_clocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd4 || mode_o == 4'd5) |-> (!core_clk_en_o && sys_clk_en_o == '0));

   p_retain_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd7 && wake_i) |=> (mode_o == 4'd0));

   p_retain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd7 && !wake_i) |=> (mode_o == 4'd7));

endmodule

bind dbg_lpm_ctrl dbg_lpm_ctrl_chk #(.NUM_SYS_CLK(NUM_SYS_CLK)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .secure_i         (secure_i),
   .sys_pwr_req_i    (sys_pwr_req_i),
   .dbg_pwr_req_i    (dbg_pwr_req_i),
   .mode_req_valid_i (mode_req_valid_i),
   .mode_req_i       (mode_req_i),
   .wake_i           (wake_i),
   .sys_pwr_ack_o    (sys_pwr_ack_o),
   .dbg_pwr_ack_o    (dbg_pwr_ack_o),
   .mode_o           (mode_o),
   .reg_run_o        (reg_run_o),
   .clk_src_en_o     (clk_src_en_o),
   .sys_clk_en_o     (sys_clk_en_o),
   .core_clk_en_o    (core_clk_en_o),
   .periph_block_o   (periph_block_o)
);

// File: tb/dbg_lpm_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_lpm_ctrl_bench;

   localparam int NSC   = 4;
   localparam int LIMIT = 200000;

   logic           clk = 1'b0;
   logic           rst_n, secure, sys_req, dbg_req, req_valid, wake;
   logic [3:0]     req_mode;
   logic           sys_ack, dbg_ack, reg_run, clk_src, core_en, pblock;
   logic [3:0]     mode;
   logic [NSC-1:0] sys_en;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   dbg_lpm_ctrl #(.NUM_SYS_CLK(NSC)) u_dbg_lpm_ctrl (
      .clk              (clk),
      .rst_n            (rst_n),
      .secure_i         (secure),
      .sys_pwr_req_i    (sys_req),
      .dbg_pwr_req_i    (dbg_req),
      .mode_req_valid_i (req_valid),
      .mode_req_i       (req_mode),
      .wake_i           (wake),
      .sys_pwr_ack_o    (sys_ack),
      .dbg_pwr_ack_o    (dbg_ack),
      .mode_o           (mode),
      .reg_run_o        (reg_run),
      .clk_src_en_o     (clk_src),
      .sys_clk_en_o     (sys_en),
      .core_clk_en_o    (core_en),
      .periph_block_o   (pblock)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT) begin
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic request(input logic [3:0] code);
      req_valid = 1'b1;
      req_mode  = code;
      step();
      req_valid = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      step();
      wake = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 mode", mode, 0);
      check("R1 acks", {sys_ack, dbg_ack}, 0);
      check("R1 reg/src/core", {reg_run, clk_src, core_en}, 3'b111);
      check("R1 sys clocks", sys_en, 4'hF);
      check("R1 block", pblock, 0);
   endtask

   task automatic t_acks();
      sys_req = 1'b1; step();
      check("R2 sys ack alone", {sys_ack, dbg_ack}, 2'b10);
      dbg_req = 1'b1; step();
      check("R2 both acks", {sys_ack, dbg_ack}, 2'b11);
      sys_req = 1'b0; step();
      check("R4 sys ack drop", {sys_ack, dbg_ack}, 2'b01);
      dbg_req = 1'b0; step();
      check("R4 dbg ack drop", {sys_ack, dbg_ack}, 2'b00);
   endtask

   task automatic t_secure();
      secure = 1'b1; sys_req = 1'b1; dbg_req = 1'b1; step();
      check("R3 no acks when secure", {sys_ack, dbg_ack}, 0);
      request(4'd4);
      check("R3 real stop when secure", mode, 4);
      check("R8 stop core/sys", {core_en, sys_en}, 0);
      check("R8 stop reg/src", {reg_run, clk_src}, 0);
      check("R6 no block in stop", pblock, 0);
      pulse_wake();
      check("R11 stop wake", mode, 0);
      secure = 1'b0; sys_req = 1'b0; dbg_req = 1'b0; step();
   endtask

   task automatic t_emulated();
      sys_req = 1'b1; dbg_req = 1'b1; step();
      request(4'd2);
      check("R12 lp run mode", mode, 2);
      check("R12 lp run reg/src/core", {reg_run, clk_src, core_en}, 3'b011);
      check("R12 lp run sys clocks", sys_en, 4'hF);
      request(4'd5);
      check("R5 emu entry from lp stop", mode, 6);
      check("R6 emu reg/src/core/block", {reg_run, clk_src, core_en, pblock}, 4'hF);
      check("R6 emu sys clocks", sys_en, 0);
      check("R2 acks held in emu", {sys_ack, dbg_ack}, 2'b11);
      dbg_req = 1'b0; step();
      check("R7 exit on req drop", mode, 2);
      dbg_req = 1'b1; step();
      request(4'd4);
      check("R5 emu entry from stop", mode, 6);
      pulse_wake();
      check("R7 exit on wake", mode, 2);
      check("R6 block off after exit", pblock, 0);
      request(4'd0);
      check("R10 back to run", mode, 0);
   endtask

   task automatic t_retain();
      step();
      check("R2 acks before retain", {sys_ack, dbg_ack}, 2'b11);
      request(4'd7);
      check("R4 retain mode", mode, 7);
      check("R4 acks drop on entry", {sys_ack, dbg_ack}, 0);
      request(4'd0);
      check("R10 request ignored in retain", mode, 7);
      check("R4 acks stay low", {sys_ack, dbg_ack}, 0);
      pulse_wake();
      check("R9 retain wake to run", mode, 0);
      check("R9 acks back on wake edge", {sys_ack, dbg_ack}, 2'b11);
      sys_req = 1'b0; dbg_req = 1'b0; step();
   endtask

   task automatic t_codes();
      request(4'd6);
      check("R10 code 6 ignored", mode, 0);
      request(4'd9);
      check("R10 code 9 ignored", mode, 0);
      request(4'd1);
      check("R12 idle mode", mode, 1);
      check("R12 idle reg/src/core", {reg_run, clk_src, core_en}, 3'b110);
      check("R12 idle sys clocks", sys_en, 4'hF);
      pulse_wake();
      check("R11 idle wake", mode, 0);
      sys_req = 1'b1; step();
      request(4'd5);
      check("R8 one request lp stop", mode, 5);
      check("R8 lp stop core", core_en, 0);
      pulse_wake();
      check("R11 lp stop wake", mode, 2);
      request(4'd3);
      check("R10 lp idle", mode, 3);
      pulse_wake();
      check("R11 lp idle wake", mode, 2);
      request(4'd8);
      check("R4 deep off mode", mode, 8);
      check("R4 deep off ack", sys_ack, 0);
      pulse_wake();
      check("R11 deep off wake", mode, 0);
      sys_req = 1'b0; step();
   endtask

   initial begin
      rst_n = 1'b0; secure = 1'b0; sys_req = 1'b0; dbg_req = 1'b0;
      req_valid = 1'b0; req_mode = 4'd0; wake = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      t_reset();
      step();
      t_acks();
      t_secure();
      t_emulated();
      t_retain();
      t_codes();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule